// File: doc/BRIEF.md
# Timer Channel with Capture/Compare Event Flags

This block is one channel of a general-purpose timer. It holds a 16-bit counter that steps once per enabled cycle. The counter normally counts up. When up/down operation is enabled, it can count down instead. Two general registers, A and B, sit beside the counter. Each one is set by its own mode pin to act as a compare register or as a capture register. In compare mode, the register raises its event when the counter steps onto the register's value. In capture mode, a strobe copies the counter into the register and raises the event.

Three sticky flags record what has happened: a wrap of the counter in either direction, an A event and a B event. The flags appear in an 8-bit status byte and are also ORed onto a single event line. Software clears a flag in two steps. It first reads the status while that flag is 1, then writes a 0 to that bit. A new event that lands in the same cycle as the clearing write keeps the flag set.

A small register bus gives access to the counter, A, B and the status byte. Reads are combinational. Writes take effect at the next clock edge.

Top module: `tmr_status_ch`

## Requirements
- R1: Status bits 7..3 always read as 1 and are unchanged by any write.
- R2: After reset, the three flags (bit 2 wrap, bit 1 B, bit 0 A) are 0, the counter is 0x0000, and A and B hold 0xFFFF.
- R3: When the counter steps up from 0xFFFF to 0x0000, it sets status bit 2 at that same clock edge.
- R4: When count_down is 1 and updown_en is 1, the counter decrements instead of incrementing. A step from 0x0000 to 0xFFFF sets status bit 2. When updown_en is 0, count_down has no effect and the counter only increments.
- R5: When a register is in compare mode (its cap_mode pin is 0), a count step that makes the counter equal to that register sets the register's flag (A on bit 0, B on bit 1) at that edge.
- R6: When a register is in capture mode, its strobe loads the counter value of that same cycle into the register and sets the register's flag. In compare mode the strobe has no effect.
- R7: A status write (address 3) with bit k equal to 0 clears flag k only if a status read that returned flag k as 1 came before it. The clearing write consumes that read. A write of 0 with no such read leaves the flag set.
- R8: Writing 1 to a flag bit leaves the flag unchanged and keeps it clearable by a later write of 0.
- R9: When a setting event and a valid clearing write hit the same flag in the same cycle, the flag stays 1.
- R10: event_o is 1 exactly when at least one of the three flags is 1.
- R11: Bus addresses are 0 for the counter, 1 for A, 2 for B and 3 for status (read as {8'h00, status}). A counter write takes priority over a count step in the same cycle. A capture takes priority over a bus write to the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_en | input | 1 | Counter steps this cycle |
| count_down | input | 1 | Step direction request (1 = down) |
| updown_en | input | 1 | Allows down-counting |
| cap_mode_a | input | 1 | Register A in capture mode when 1 |
| cap_mode_b | input | 1 | Register B in capture mode when 1 |
| cap_a | input | 1 | Capture strobe for A |
| cap_b | input | 1 | Capture strobe for B |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| status_o | output | 8 | Status byte |
| event_o | output | 1 | OR of the three flags |

## Verification
The hardest case to reach from the ports is the race between a clearing write and a new event on the same flag. The bench first arms the flag with a status read. It then issues the clearing write in the very cycle a capture strobe fires. Afterwards it checks that the flag survived and that the arming was consumed, so a second bare write of 0 must not clear it. Long random phases also cross counter writes, wraps in both directions and capture strobes with read-then-write sequences. A behavioural model is compared with the outputs on every clock.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
    localparam int NFLAG = 3;
    localparam int FLAG_A = 0;
    localparam int FLAG_B = 1;
    localparam int FLAG_WRAP = 2;
    localparam logic [1:0] ADDR_CNT = 2'd0;
    localparam logic [1:0] ADDR_GRA = 2'd1;
    localparam logic [1:0] ADDR_GRB = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;
    localparam logic [4:0] STAT_RSVD = 5'b11111;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         dir_down,
    input  logic         updown_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_next,
    output logic         stepped,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    go_down;

    always_comb begin
        st_d    = st_q;
        go_down = updown_en & dir_down;
        stepped = step_en & ~load;
        if (load) begin
            st_d.cnt = load_val;
        end else if (step_en) begin
            st_d.cnt = go_down ? st_q.cnt - 1'b1 : st_q.cnt + 1'b1;
        end
        wrap = stepped & (go_down ? (st_q.cnt == '0) : (st_q.cnt == '1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q    = st_q.cnt;
    assign cnt_next = st_d.cnt;
endmodule

// File: rtl/tmr_genreg.sv
module tmr_genreg #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode,
    input  logic         cap_strobe,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cnt_next,
    input  logic         stepped,
    output logic [W-1:0] reg_q,
    output logic         hit
);
    typedef struct packed {
        logic [W-1:0] val;
    } gr_st_t;

    gr_st_t st_d, st_q;
    logic   do_cap;

    always_comb begin
        st_d   = st_q;
        do_cap = cap_mode & cap_strobe;
        if (do_cap) begin
            st_d.val = cnt_q;
        end else if (load) begin
            st_d.val = load_val;
        end
        hit = do_cap | (~cap_mode & stepped & (cnt_next == st_q.val));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.val <= RST_VAL;
        else        st_q     <= st_d;
    end

    assign reg_q = st_q.val;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic         rd_stat,
    input  logic         wr_stat,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] flags_q
);
    typedef struct packed {
        logic [N-1:0] flag;
        logic [N-1:0] armed;
    } fl_st_t;

    fl_st_t       st_d, st_q;
    logic [N-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = {N{wr_stat}} & ~wr_bits & st_q.armed;
        st_d.flag = (st_q.flag & ~clr) | set_ev;
        if (rd_stat) st_d.armed = st_d.armed | st_q.flag;
        if (wr_stat) st_d.armed = st_d.armed & wr_bits;
        st_d.armed = st_d.armed & st_d.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flag;
endmodule

// File: rtl/tmr_status_ch.sv
module tmr_status_ch #(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] GR_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             count_down,
    input  logic             updown_en,
    input  logic             cap_mode_a,
    input  logic             cap_mode_b,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic [7:0]       status_o,
    output logic             event_o
);
    import tmr_stat_pkg::*;

    localparam int NGR = 2;

    logic [CNT_W-1:0] cnt_q, cnt_next;
    logic             stepped, wrap;
    logic [NGR-1:0]   gr_mode, gr_cap, gr_load, gr_hit;
    logic [CNT_W-1:0] gr_q [NGR];
    logic [CNT_W-1:0] gra_q, grb_q;
    logic [NFLAG-1:0] flags_q, set_ev;
    logic             sel_cnt, sel_stat;

    assign sel_cnt  = bus_addr == ADDR_CNT;
    assign sel_stat = bus_addr == ADDR_STAT;

    tmr_counter #(.W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .step_en(count_en), .dir_down(count_down),
        .updown_en(updown_en), .load(bus_wr & sel_cnt), .load_val(bus_wdata),
        .cnt_q(cnt_q), .cnt_next(cnt_next), .stepped(stepped), .wrap(wrap)
    );

    assign gr_mode = {cap_mode_b, cap_mode_a};
    assign gr_cap  = {cap_b, cap_a};
    assign gr_load = {bus_wr & (bus_addr == ADDR_GRB), bus_wr & (bus_addr == ADDR_GRA)};

    for (genvar g = 0; g < NGR; g++) begin : g_gr
        tmr_genreg #(.W(CNT_W), .RST_VAL(GR_RESET)) i_gr (
            .clk(clk), .rst_n(rst_n), .cap_mode(gr_mode[g]), .cap_strobe(gr_cap[g]),
            .load(gr_load[g]), .load_val(bus_wdata), .cnt_q(cnt_q),
            .cnt_next(cnt_next), .stepped(stepped), .reg_q(gr_q[g]), .hit(gr_hit[g])
        );
    end

    assign gra_q = gr_q[0];
    assign grb_q = gr_q[1];

    always_comb begin
        set_ev            = '0;
        set_ev[FLAG_A]    = gr_hit[0];
        set_ev[FLAG_B]    = gr_hit[1];
        set_ev[FLAG_WRAP] = wrap;
    end

    tmr_flags #(.N(NFLAG)) i_flags (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .rd_stat(bus_rd & sel_stat),
        .wr_stat(bus_wr & sel_stat), .wr_bits(bus_wdata[NFLAG-1:0]), .flags_q(flags_q)
    );

    assign status_o = {STAT_RSVD, flags_q};
    assign event_o  = |flags_q;

    always_comb begin
        case (bus_addr)
            ADDR_CNT: bus_rdata = cnt_q;
            ADDR_GRA: bus_rdata = gra_q;
            ADDR_GRB: bus_rdata = grb_q;
            default:  bus_rdata = {{(CNT_W-8){1'b0}}, status_o};
        endcase
    end
endmodule

// File: rtl/tmr_status_ch_chk.sv
module tmr_status_ch_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             count_en,
    input logic             count_down,
    input logic             updown_en,
    input logic             cap_mode_a,
    input logic             cap_a,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic [7:0]       status_o,
    input logic             event_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] gra_q
);
    logic wr_stat, wr_cnt;
    assign wr_stat = bus_wr && bus_addr == 2'd3;
    assign wr_cnt  = bus_wr && bus_addr == 2'd0;

    assert_rsvd_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:3] == 5'b11111);

    assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !(updown_en && count_down) && cnt_q == '1 && !wr_cnt) |=> status_o[2]);

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !updown_en && cnt_q == '0 && !wr_cnt) |=> (cnt_q == 1));

    assert_capture_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_a && cap_mode_a) |=> (gra_q == $past(cnt_q)) && status_o[0]);

    assert_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> $past(wr_stat && !bus_wdata[0]));

    assert_clear_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[2]) |-> $past(wr_stat && !bus_wdata[2]));

    assert_write_one_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[1] && status_o[1]) |=> status_o[1]);

    assert_event_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2:0] != 3'b000) |-> event_o);

    assert_event_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2:0] == 3'b000) |-> !event_o);
endmodule

bind tmr_status_ch tmr_status_ch_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .count_down(count_down),
    .updown_en(updown_en), .cap_mode_a(cap_mode_a), .cap_a(cap_a), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_o(status_o), .event_o(event_o),
    .cnt_q(cnt_q), .gra_q(gra_q)
);

// File: tb/test_tmr_status_ch.sv
`timescale 1ns/1ps
module test_tmr_status_ch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 0, count_down = 0, updown_en = 0;
    logic        cap_mode_a = 0, cap_mode_b = 0, cap_a = 0, cap_b = 0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic [7:0]  status_o;
    logic        event_o;

    int total = 0;
    int bad = 0;
    string cur_req = "R2";

    int m_cnt, m_ga, m_gb;
    logic [2:0] m_f, m_arm;

    always #2.5 clk = ~clk;

    tmr_status_ch i_tmr_status_ch (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .count_down(count_down),
        .updown_en(updown_en), .cap_mode_a(cap_mode_a), .cap_mode_b(cap_mode_b),
        .cap_a(cap_a), .cap_b(cap_b), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status_o(status_o), .event_o(event_o)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_ga;
            2'd2: return m_gb;
            default: return {24'd0, 5'b11111, m_f};
        endcase
    endfunction

    task automatic model_step();
        int nc, na, nb;
        logic dn, cw, mv, ha, hb, wr_s;
        logic [2:0] set, clr, nf, narm;
        dn = updown_en && count_down;
        cw = bus_wr && bus_addr == 0;
        mv = count_en && !cw;
        nc = m_cnt;
        if (cw) nc = bus_wdata;
        else if (count_en) nc = dn ? (m_cnt + 65535) % 65536 : (m_cnt + 1) % 65536;
        set[2] = mv && (dn ? m_cnt == 0 : m_cnt == 65535);
        na = m_ga; nb = m_gb;
        if (cap_mode_a && cap_a) na = m_cnt;
        else if (bus_wr && bus_addr == 1) na = bus_wdata;
        if (cap_mode_b && cap_b) nb = m_cnt;
        else if (bus_wr && bus_addr == 2) nb = bus_wdata;
        ha = cap_mode_a ? cap_a : (mv && nc == m_ga);
        hb = cap_mode_b ? cap_b : (mv && nc == m_gb);
        set[0] = ha; set[1] = hb;
        wr_s = bus_wr && bus_addr == 3;
        clr = wr_s ? (~bus_wdata[2:0] & m_arm) : 3'b000;
        nf = (m_f & ~clr) | set;
        narm = m_arm;
        if (bus_rd && bus_addr == 3) narm = narm | m_f;
        if (wr_s) narm = narm & bus_wdata[2:0];
        narm = narm & nf;
        m_cnt = nc; m_ga = na; m_gb = nb; m_f = nf; m_arm = narm;
    endtask

    task automatic cyc();
        #1;
        if (bus_rd) check(bus_rdata, model_read(bus_addr), cur_req, "read data");
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(status_o, {24'd0, 5'b11111, m_f}, cur_req, "status vs model");
        check(event_o, |m_f, "R10", "event line vs model");
    endtask

    task automatic idle_bus();
        bus_rd = 0; bus_wr = 0; cap_a = 0; cap_b = 0; count_en = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        idle_bus(); bus_wr = 1; bus_addr = a; bus_wdata = d; cyc(); bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        idle_bus(); bus_rd = 1; bus_addr = a; cyc(); bus_rd = 0;
    endtask

    task automatic cnt(input int n);
        idle_bus(); count_en = 1;
        for (int i = 0; i < n; i++) cyc();
        count_en = 0;
    endtask

    task automatic peek(input logic [1:0] a, input int exp, input string req);
        idle_bus(); bus_addr = a; #1;
        check(bus_rdata, exp, req, "register value");
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_cnt = 0; m_ga = 16'hFFFF; m_gb = 16'hFFFF; m_f = 0; m_arm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        check(status_o, 8'hF8, "R2", "status after reset");
        check(event_o, 0, "R10", "event after reset");
        peek(0, 16'h0000, "R2");
        peek(1, 16'hFFFF, "R2");
        peek(2, 16'hFFFF, "R2");
        // R11 register writes
        cur_req = "R11";
        wr(1, 16'h8000); wr(2, 16'h8000);
        wr(0, 16'hFFFD);
        peek(0, 16'hFFFD, "R11");
        peek(1, 16'h8000, "R11");
        rd(3);
        // R1 writes to reserved bits ignored
        cur_req = "R1";
        wr(3, 16'hFFFF);
        check(status_o, 8'hF8, "R1", "reserved after write");
        wr(3, 16'h0000);
        check(status_o, 8'hF8, "R1", "reserved after zero write");
        // R3 overflow
        cur_req = "R3";
        cnt(2);
        check(status_o, 8'hF8, "R3", "no wrap yet");
        cnt(1);
        check(status_o, 8'hFC, "R3", "wrap up sets bit2");
        check(event_o, 1, "R10", "event with wrap");
        peek(0, 16'h0000, "R3");
        // R7 clear needs prior read
        cur_req = "R7";
        wr(3, 16'h0000);
        check(status_o, 8'hFC, "R7", "write 0 without read");
        rd(3);
        wr(3, 16'h0000);
        check(status_o, 8'hF8, "R7", "read then write 0 clears");
        check(event_o, 0, "R10", "event cleared");
        // R8 write 1 keeps flag
        cur_req = "R8";
        wr(0, 16'hFFFF); cnt(1);
        rd(3);
        wr(3, 16'h0004);
        check(status_o, 8'hFC, "R8", "write 1 keeps flag");
        wr(3, 16'h0000);
        check(status_o, 8'hF8, "R8", "still armed after write 1");
        // R4 down counting
        cur_req = "R4";
        wr(0, 16'h0000);
        idle_bus(); updown_en = 0; count_down = 1; cnt(1);
        peek(0, 16'h0001, "R4");
        check(status_o, 8'hF8, "R4", "count_down ignored when disabled");
        updown_en = 1; cnt(2);
        peek(0, 16'hFFFF, "R4");
        check(status_o, 8'hFC, "R4", "underflow sets bit2");
        rd(3); wr(3, 16'h0000);
        updown_en = 0; count_down = 0;
        // R5 compare
        cur_req = "R5";
        wr(1, 16'h0010); wr(2, 16'h0011); wr(0, 16'h000E);
        cnt(1);
        check(status_o, 8'hF8, "R5", "no match yet");
        cnt(1);
        check(status_o, 8'hF9, "R5", "A match");
        cnt(1);
        check(status_o, 8'hFB, "R5", "B match");
        rd(3); wr(3, 16'h0000);
        check(status_o, 8'hF8, "R5", "cleared");
        // R6 capture
        cur_req = "R6";
        cap_mode_a = 1;
        wr(0, 16'h1234);
        idle_bus(); cap_a = 1; cyc(); cap_a = 0;
        check(status_o, 8'hF9, "R6", "capture sets A flag");
        peek(1, 16'h1234, "R6");
        idle_bus(); cap_b = 1; cyc(); cap_b = 0;
        check(status_o, 8'hF9, "R6", "strobe ignored in compare mode");
        peek(2, 16'h0011, "R6");
        // R9 set wins
        cur_req = "R9";
        rd(3);
        idle_bus(); bus_wr = 1; bus_addr = 3; bus_wdata = 0; cap_a = 1; cyc();
        idle_bus();
        check(status_o, 8'hF9, "R9", "set beats clear");
        wr(3, 16'h0000);
        check(status_o, 8'hF9, "R7", "arming consumed by write");
        rd(3); wr(3, 16'h0000);
        check(status_o, 8'hF8, "R7", "cleared after new read");
        // random phase
        cur_req = "R3/R4/R5/R6/R7/R9/R11";
        for (int i = 0; i < 4000; i++) begin
            int r;
            idle_bus();
            if (i % 300 == 0) begin
                updown_en = $urandom_range(0, 1);
                cap_mode_a = $urandom_range(0, 1);
                cap_mode_b = $urandom_range(0, 1);
            end
            count_en = $urandom_range(0, 3) != 0;
            count_down = $urandom_range(0, 1);
            cap_a = $urandom_range(0, 9) == 0;
            cap_b = $urandom_range(0, 9) == 0;
            r = $urandom_range(0, 9);
            bus_addr = $urandom_range(0, 3);
            if (r < 3) bus_rd = 1;
            else if (r < 5) begin
                bus_wr = 1;
                bus_wdata = (bus_addr == 0) ? 16'(16'hFFFC + $urandom_range(0, 7))
                                           : 16'($urandom_range(0, 65535));
                if (bus_addr != 0 && $urandom_range(0, 1) == 1) bus_wdata = 16'($urandom_range(0, 7));
            end
            cyc();
        end
        idle_bus();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule